// File: doc/BRIEF.md
# Single-Wire Slave ID Command Selector

This block is the addressing layer of a slave device on a single-conductor bus. Each bus reset/presence sequence is reported to it as a pulse. It then collects one 8-bit ID command from the master and settles whether this device is the one the master is addressing. Once it has decided that, the memory-function layer above it may take over. The device carries a fixed 64-bit identifier, set by a parameter. The master can read this identifier or compare against it. It can also find it by a bitwise arbitration search, or skip addressing altogether. Two further skip variants resume an earlier selection or switch the device into the fast bus speed.

Bits pass through two valid/ready streams, one per bit slot. The receive stream carries bits that the master writes. A handshake on it is `rx_valid && rx_ready`. The block lowers `rx_ready` while it has a bit to send. The transmit stream carries bits the device answers in master-initiated read slots. A read slot consumes the offered bit when `tx_valid && tx_ready`. While `tx_ready` is low, the block holds `tx_valid` and `tx_bit` steady, so back-pressure simply stalls the sequence. Slot timing, sampling points and the analog side are outside this block. The `bus_reset` and `reset_long` pins are plain control inputs, and so are the `selected` and `overdrive` outputs.

Top module: `sws_id_select`

## Requirements
- R1: After `rst_n` the block is idle, with `selected` and `overdrive` low, `tx_valid` low and `rx_ready` high. A `bus_reset` pulse starts collection of a command byte whose first received bit is bit 0, and it deselects the device.
- R2: Command CCh selects the device in the cycle after its eighth bit is accepted.
- R3: Command 33h offers the 64 identifier bits on the transmit stream, bit 0 first, and selects the device after the last one is taken.
- R4: Command 55h compares the next 64 received bits, bit 0 first, against the identifier. It selects the device only if every bit agrees. On the first differing bit it drops to idle.
- R5: Command F0h runs 64 search rounds. In each round the device offers the identifier bit, then its inverse, then accepts the master's bit. If that bit differs from the identifier bit, the device goes idle and offers nothing more. After round 63 it is selected.
- R6: Command A5h selects the device only when the resume flag is set. A completed 55h or F0h sets the flag, and so do CCh and 3Ch. Every other command byte clears it, 33h and unknown codes included. A5h leaves it unchanged.
- R7: Command 3Ch selects the device and raises `overdrive`. A reset with `reset_long` high clears `overdrive`. A reset with `reset_long` low keeps it.
- R8: Any other command byte sends the device idle. In idle, further received bits are accepted and have no effect until the next `bus_reset`.
- R9: `rx_ready` is low whenever `tx_valid` is high. While `tx_ready` is low, `tx_valid` and `tx_bit` stay unchanged. Once the device is selected, received bits are accepted and discarded, and `selected` stays high.
- R10: A `bus_reset` during any sequence abandons it. The next eight received bits form a fresh command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | One-cycle pulse: bus reset/presence finished |
| reset_long | input | 1 | Qualifies `bus_reset`: it was a standard-speed length reset |
| rx_valid | input | 1 | Master has written a bit |
| rx_bit | input | 1 | Value of the written bit |
| rx_ready | output | 1 | Block accepts a written bit |
| tx_valid | output | 1 | Block has a bit for the next read slot |
| tx_bit | output | 1 | Bit value to answer |
| tx_ready | input | 1 | Read slot consumes the offered bit |
| selected | output | 1 | Device is addressed; memory functions may follow |
| overdrive | output | 1 | Device runs at the fast bus speed |

## Verification
The bench flips identifier bit 63 during a match, because a design that checked fewer than 64 bits would select the device wrongly. It also loses a search at round 5, where a design that did not drop out would keep driving the bus. It walks resume commands after a successful selection, after an unknown byte and after a failed match, which exposes a resume flag cleared or set by the wrong command. It issues short and long resets in fast mode, which catches a speed flag that is reset by any reset or by none. It stalls the read slot, aborts a match with a reset, and feeds bits to a selected device, which catches a dropped transmit bit, a stale bit counter, or a selection lost to trailing bits.

// File: rtl/sws_pkg.sv
package sws_pkg;
  localparam int unsigned CMD_W = 8;

  localparam logic [CMD_W-1:0] OP_READ_ID   = 8'h33;
  localparam logic [CMD_W-1:0] OP_MATCH_ID  = 8'h55;
  localparam logic [CMD_W-1:0] OP_SEARCH_ID = 8'hF0;
  localparam logic [CMD_W-1:0] OP_SKIP      = 8'hCC;
  localparam logic [CMD_W-1:0] OP_RESUME    = 8'hA5;
  localparam logic [CMD_W-1:0] OP_FAST_SKIP = 8'h3C;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_READ,
    ST_MATCH,
    ST_SRCH_B,
    ST_SRCH_C,
    ST_SRCH_W,
    ST_SEL
  } sws_state_e;
endpackage

// File: rtl/sws_id_bit.sv
module sws_id_bit #(
  parameter int unsigned ID_W = 64,
  parameter logic [ID_W-1:0] ID = '0,
  localparam int unsigned IW = $clog2(ID_W)
) (
  input  logic [IW-1:0] idx,
  output logic          bit_o
);
  always_comb bit_o = ID[idx];
endmodule

// File: rtl/sws_cmd_decode.sv
module sws_cmd_decode
  import sws_pkg::*;
(
  input  logic [CMD_W-1:0] code,
  input  logic             resume_flag,
  output sws_state_e       nxt
);
  always_comb begin
    unique case (code)
      OP_READ_ID:             nxt = ST_READ;
      OP_MATCH_ID:            nxt = ST_MATCH;
      OP_SEARCH_ID:           nxt = ST_SRCH_B;
      OP_SKIP, OP_FAST_SKIP:  nxt = ST_SEL;
      OP_RESUME:              nxt = resume_flag ? ST_SEL : ST_IDLE;
      default:                nxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/sws_flags.sv
module sws_flags
  import sws_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_reset,
  input  logic             reset_long,
  input  logic             decode_fire,
  input  logic [CMD_W-1:0] code,
  input  logic             win,
  output logic             resume_flag,
  output logic             overdrive
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resume_flag <= 1'b0;
    end else if (decode_fire) begin
      if (code == OP_SKIP || code == OP_FAST_SKIP) resume_flag <= 1'b1;
      else if (code != OP_RESUME)                  resume_flag <= 1'b0;
    end else if (win) begin
      resume_flag <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overdrive <= 1'b0;
    end else if (bus_reset && reset_long) begin
      overdrive <= 1'b0;
    end else if (decode_fire && code == OP_FAST_SKIP) begin
      overdrive <= 1'b1;
    end
  end

  assert_od_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset && reset_long) |=> !overdrive);
  assert_od_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (decode_fire && code == OP_FAST_SKIP && !bus_reset) |=> overdrive);
  assert_resume_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (decode_fire && code != OP_RESUME && code != OP_SKIP && code != OP_FAST_SKIP)
      |=> !resume_flag);
endmodule

// File: rtl/sws_id_select.sv
module sws_id_select
  import sws_pkg::*;
#(
  parameter int unsigned ID_W = 64,
  parameter logic [ID_W-1:0] ID = 64'h5E00_0012_34AB_CD2D,
  localparam int unsigned IW = $clog2(ID_W)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_reset,
  input  logic reset_long,
  input  logic rx_valid,
  input  logic rx_bit,
  output logic rx_ready,
  output logic tx_valid,
  output logic tx_bit,
  input  logic tx_ready,
  output logic selected,
  output logic overdrive
);
  sws_state_e           state, dec_nxt;
  logic [IW-1:0]        idx;
  logic [CMD_W-2:0]     cmd_sr;
  logic [CMD_W-1:0]     cmd_full;
  logic                 id_bit, rx_fire, tx_fire, last_id, last_cmd;
  logic                 decode_fire, win, resume_flag;

  sws_id_bit #(.ID_W(ID_W), .ID(ID)) u_id_bit (.idx(idx), .bit_o(id_bit));

  assign cmd_full = {rx_bit, cmd_sr};

  sws_cmd_decode u_dec (.code(cmd_full), .resume_flag(resume_flag), .nxt(dec_nxt));

  always_comb begin
    tx_valid = (state == ST_READ) || (state == ST_SRCH_B) || (state == ST_SRCH_C);
    tx_bit   = (state == ST_SRCH_C) ? ~id_bit : id_bit;
    rx_ready = !tx_valid;
    selected = (state == ST_SEL);
    rx_fire  = rx_valid && rx_ready;
    tx_fire  = tx_valid && tx_ready;
    last_id  = (idx == IW'(ID_W - 1));
    last_cmd = (idx == IW'(CMD_W - 1));
    decode_fire = !bus_reset && state == ST_CMD && rx_fire && last_cmd;
    win = !bus_reset && rx_fire && last_id && (rx_bit == id_bit) &&
          (state == ST_MATCH || state == ST_SRCH_W);
  end

  sws_flags u_flags (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .reset_long(reset_long),
    .decode_fire(decode_fire), .code(cmd_full), .win(win),
    .resume_flag(resume_flag), .overdrive(overdrive)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      idx    <= '0;
      cmd_sr <= '0;
    end else if (bus_reset) begin
      state  <= ST_CMD;
      idx    <= '0;
    end else begin
      unique case (state)
        ST_CMD: if (rx_fire) begin
          cmd_sr <= {rx_bit, cmd_sr[CMD_W-2:1]};
          if (last_cmd) begin
            idx   <= '0;
            state <= dec_nxt;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_READ: if (tx_fire) begin
          if (last_id) state <= ST_SEL;
          idx <= idx + 1'b1;
        end
        ST_MATCH: if (rx_fire) begin
          if (rx_bit != id_bit) state <= ST_IDLE;
          else if (last_id)     state <= ST_SEL;
          idx <= idx + 1'b1;
        end
        ST_SRCH_B: if (tx_fire) state <= ST_SRCH_C;
        ST_SRCH_C: if (tx_fire) state <= ST_SRCH_W;
        ST_SRCH_W: if (rx_fire) begin
          if (rx_bit != id_bit) state <= ST_IDLE;
          else if (last_id)     state <= ST_SEL;
          else                  state <= ST_SRCH_B;
          idx <= idx + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assert_reset_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (!selected && !tx_valid && rx_ready));
  assert_skip_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (decode_fire && cmd_full == OP_SKIP) |=> selected);
  assert_match_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_reset && state == ST_MATCH && rx_fire && rx_bit != id_bit) |=> !selected);
  assert_search_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_reset && state == ST_SRCH_W && rx_fire && rx_bit != id_bit)
      |=> (!selected && !tx_valid));
  assert_resume_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (decode_fire && cmd_full == OP_RESUME && !resume_flag) |=> !selected);
  assert_tx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !bus_reset) |=> (tx_valid && $stable(tx_bit)));
  assert_sel_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (selected && !bus_reset) |=> selected);
endmodule

// File: tb/sws_id_select_bench.sv
module sws_id_select_bench;
  localparam logic [63:0] BID = 64'hC3A5_0F19_7E62_D481;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_reset = 1'b0, reset_long = 1'b0;
  logic rx_valid = 1'b0, rx_bit = 1'b0, tx_ready = 1'b0;
  logic rx_ready, tx_valid, tx_bit, selected, overdrive;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #4 clk = ~clk;

  sws_id_select #(.ID_W(64), .ID(BID)) u_sws_id_select (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .reset_long(reset_long),
    .rx_valid(rx_valid), .rx_bit(rx_bit), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_bit(tx_bit), .tx_ready(tx_ready),
    .selected(selected), .overdrive(overdrive)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: act=hung exp=finished");
      summary();
    end
  end

  task automatic check(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic lng);
    @(negedge clk); bus_reset = 1'b1; reset_long = lng;
    @(posedge clk); #1; bus_reset = 1'b0; reset_long = 1'b0;
  endtask

  task automatic put_bit(input logic b);
    @(negedge clk); rx_valid = 1'b1; rx_bit = b;
    while (!rx_ready) @(negedge clk);
    @(posedge clk); #1; rx_valid = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) put_bit(v[i]);
  endtask

  task automatic get_bit(output logic b);
    @(negedge clk); tx_ready = 1'b1;
    while (!tx_valid) @(negedge clk);
    b = tx_bit;
    @(posedge clk); #1; tx_ready = 1'b0;
  endtask

  // {reset_long, command, expected selected, expected overdrive}
  localparam int NV = 9;
  localparam logic [10:0] VEC [NV] = '{
    {1'b1, 8'hCC, 1'b1, 1'b0},
    {1'b1, 8'hA5, 1'b1, 1'b0},
    {1'b1, 8'h99, 1'b0, 1'b0},
    {1'b1, 8'hA5, 1'b0, 1'b0},
    {1'b1, 8'h3C, 1'b1, 1'b1},
    {1'b0, 8'hA5, 1'b1, 1'b1},
    {1'b0, 8'h00, 1'b0, 1'b1},
    {1'b1, 8'hA5, 1'b0, 1'b0},
    {1'b1, 8'hCC, 1'b1, 1'b0}
  };

  initial begin
    logic b, c;
    logic [63:0] got;
    logic okc;
    repeat (3) @(posedge clk);
    #1;
    check(!selected && !overdrive && !tx_valid && rx_ready, "R1 reset state",
          {selected, overdrive, tx_valid, rx_ready}, 4'b0001);
    @(negedge clk); rst_n = 1'b1;

    // Table walk: R2 skip, R6 resume flag, R7 speed, R8 unknown codes
    for (int v = 0; v < NV; v++) begin
      do_reset(VEC[v][10]);
      put_byte(VEC[v][9:2]);
      check(selected == VEC[v][1], "R2/R6/R8 selected after command", selected, VEC[v][1]);
      check(overdrive == VEC[v][0], "R7 overdrive after command", overdrive, VEC[v][0]);
    end

    // R8: bits after an unknown command stay ignored
    do_reset(1'b1);
    put_byte(8'h12);
    put_byte(8'hCC);
    check(!selected && !tx_valid, "R8 idle ignores later bits", selected, 0);

    // R3 and R9: read with stall, then collect
    do_reset(1'b1);
    put_byte(8'h33);
    okc = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (!(tx_valid && tx_bit == BID[0] && !rx_ready)) okc = 1'b0;
    end
    check(okc, "R9 tx held under stall, rx_ready low", okc, 1);
    for (int i = 0; i < 64; i++) begin get_bit(b); got[i] = b; end
    check(got == BID, "R3 read identifier", got, BID);
    check(selected, "R3 selected after read", selected, 1);
    do_reset(1'b0);
    put_byte(8'hA5);
    check(!selected, "R6 read clears resume", selected, 0);

    // R4 full match then resume
    do_reset(1'b1);
    put_byte(8'h55);
    for (int i = 0; i < 64; i++) put_bit(BID[i]);
    check(selected, "R4 full match selects", selected, 1);
    do_reset(1'b0);
    put_byte(8'hA5);
    check(selected, "R6 resume after match", selected, 1);

    // R9: bits after selection discarded
    put_byte(8'hFF);
    check(selected, "R9 selected ignores bits", selected, 1);

    // R4 mismatch at bit 63
    do_reset(1'b1);
    put_byte(8'h55);
    for (int i = 0; i < 64; i++) put_bit(i == 63 ? ~BID[i] : BID[i]);
    check(!selected, "R4 bit 63 mismatch", selected, 0);
    do_reset(1'b1);
    put_byte(8'hA5);
    check(!selected, "R6 resume after failed match", selected, 0);

    // R5 complete search
    do_reset(1'b1);
    put_byte(8'hF0);
    okc = 1'b1;
    for (int i = 0; i < 64; i++) begin
      get_bit(b); get_bit(c);
      if (c != ~b) okc = 1'b0;
      got[i] = b;
      put_bit(b);
    end
    check(okc, "R5 complement bits", okc, 1);
    check(got == BID, "R5 search bits", got, BID);
    check(selected, "R5 search selects", selected, 1);

    // R5 lose at round 5
    do_reset(1'b1);
    put_byte(8'hF0);
    for (int i = 0; i < 5; i++) begin get_bit(b); get_bit(c); put_bit(b); end
    get_bit(b); get_bit(c); put_bit(~b);
    check(!selected && !tx_valid, "R5 dropout", {selected, tx_valid}, 0);

    // R10 reset mid match
    do_reset(1'b1);
    put_byte(8'h55);
    for (int i = 0; i < 10; i++) put_bit(BID[i]);
    do_reset(1'b1);
    check(!selected && rx_ready, "R1 after bus reset", selected, 0);
    put_byte(8'hCC);
    check(selected, "R10 fresh command after abort", selected, 1);

    summary();
  end
endmodule